// File: doc/BRIEF.md
# Word-Interleaved Block Memory

This block is a main-memory subsystem that refills cache blocks. Storage is split across several banks, and consecutive word addresses sit in consecutive banks. When a block request is accepted, one row address goes to every bank at once. All banks then run their fixed-latency access in parallel. The words of the block come back one per cycle over a single word-wide return path, in ascending bank order, with a valid flag and a flag that marks the final word.

A separate single-word write port updates any word at any time, including while a block read is in progress. Only one block read is outstanding at a time. The request-ready output stays low from acceptance until the last word has been returned. With the default settings (4 banks, a 6-cycle access, a 1-cycle address phase and 1 cycle per word), a block completes in 11 cycles. A memory that is one word wide and not interleaved would need 32 cycles for the same block.

Top module: `interleaved_mem`

## Requirements
- R1: After reset, req_ready is 1, rd_valid and rd_last are 0, and every stored word reads back as zero.
- R2: A request is accepted on a rising edge where req_valid and req_ready are both 1. req_ready is 0 from the next cycle until the last word of that block has been returned.
- R3: Count the cycle that follows the accepting edge as cycle 1. rd_valid first rises in cycle ACCESS_LAT+2 (cycle 8 by default). The final word appears in cycle 1+ACCESS_LAT+NUM_BANKS (cycle 11 by default).
- R4: Word i of block b (0 ≤ i < NUM_BANKS) is the word at word address b*NUM_BANKS+i. Words are returned in ascending order of i.
- R5: rd_valid stays high for exactly NUM_BANKS consecutive cycles per block. rd_last is 1 only together with the final word.
- R6: When wr_en is 1 on a rising edge, wr_data is stored at word address wr_addr. The bank is wr_addr[1:0] and the row within the bank is wr_addr[5:2] (default widths).
- R7: Each bank samples its row on the edge ending the access phase, which is edge ACCESS_LAT+1 after acceptance. A write landing on an earlier edge is returned by the current block. A write landing on that edge or later is not returned by the current block, but is returned by the next read of that block.
- R8: req_valid and req_blk are ignored while req_ready is 0. The block in flight keeps its words and timing, and no extra words are returned.
- R9: req_ready returns to 1 in the cycle after the final word. A request held high is accepted on the next edge, so back-to-back blocks follow without further gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Block request strobe |
| req_blk | input | 4 | Block address (row shared by all banks) |
| req_ready | output | 1 | Idle and able to accept a block request |
| wr_en | input | 1 | Single-word write strobe |
| wr_addr | input | 6 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_valid | output | 1 | Return word valid |
| rd_last | output | 1 | Final word of the block |
| rd_data | output | 32 | Returned word |

## Verification
The case of interest is a single-word write that lands on the same edge as an access in progress, and above all on the exact edge where the banks sample their rows. The bench starts a block read and then times writes into three banks of that block: one before the sampling edge, one on it, and one during the transfer. A behavioural model snapshots its own storage at the sampling edge before applying that edge's write. Each returned word is compared against this snapshot, and a follow-up read of the same block must show all three new values.

// File: rtl/im_pkg.sv
// Shared types for the interleaved block memory.
package im_pkg;
    // Controller phases for one block refill.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ADDR   = 2'd1,
        ST_ACCESS = 2'd2,
        ST_XFER   = 2'd3
    } im_state_e;
endpackage

// File: rtl/im_bank.sv
// One storage bank: a register array with a single write port and a
// sampled read register.
// Assumes: rd_sample pulses once per block, at the end of the access phase.
//          A write on the same edge is not seen by that sample (old data).
module im_bank #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 16,
    localparam int ROW_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_sample,
    input  logic [ROW_W-1:0]  rd_row,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] mem_q [DEPTH];

    // Storage update and read sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            rd_word <= '0;
        end else begin
            if (wr_en)     mem_q[wr_row] <= wr_data;
            if (rd_sample) rd_word       <= mem_q[rd_row];
        end
    end
endmodule

// File: rtl/im_ctrl.sv
// Block refill sequencer: one address cycle, ACCESS_LAT access cycles,
// then NUM_BANKS transfer cycles with the bank select counting upward.
// Assumes: ACCESS_LAT >= 1 and NUM_BANKS is a power of two >= 2.
module im_ctrl
    import im_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int ACCESS_LAT = 6,
    parameter int BLK_W      = 4,
    localparam int SEL_W     = $clog2(NUM_BANKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [BLK_W-1:0] req_blk,
    output logic             req_ready,
    output logic [BLK_W-1:0] row,
    output logic             sample,
    output logic [SEL_W-1:0] sel,
    output logic             xfer_valid,
    output logic             xfer_last
);
    localparam int CNT_MAX = (ACCESS_LAT > NUM_BANKS) ? ACCESS_LAT : NUM_BANKS;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] ACC_END  = CNT_W'(ACCESS_LAT - 1);
    localparam logic [CNT_W-1:0] XFER_END = CNT_W'(NUM_BANKS - 1);

    im_state_e         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BLK_W-1:0]  row_q;

    // Phase sequencing and per-phase counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            row_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    state_q <= ST_ADDR;
                    row_q   <= req_blk;
                end
                ST_ADDR: begin
                    state_q <= ST_ACCESS;
                    cnt_q   <= '0;
                end
                ST_ACCESS: if (cnt_q == ACC_END) begin
                    state_q <= ST_XFER;
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
                ST_XFER: if (cnt_q == XFER_END) begin
                    state_q <= ST_IDLE;
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Decoded outputs of the current phase.
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        row        = row_q;
        sample     = (state_q == ST_ACCESS) && (cnt_q == ACC_END);
        sel        = cnt_q[SEL_W-1:0];
        xfer_valid = (state_q == ST_XFER);
        xfer_last  = (state_q == ST_XFER) && (cnt_q == XFER_END);
    end
endmodule

// File: rtl/interleaved_mem.sv
// Word-interleaved block memory top. The low address bits of a word pick
// its bank and the upper bits pick its row. A block read samples every
// bank in parallel, then returns the words serially in bank order.
// Assumes: one block outstanding; writes may arrive in any cycle.
module interleaved_mem #(
    parameter int WORD_W     = 32,
    parameter int NUM_BANKS  = 4,
    parameter int BANK_DEPTH = 16,
    parameter int ACCESS_LAT = 6,
    localparam int BANK_W    = $clog2(NUM_BANKS),
    localparam int ROW_W     = $clog2(BANK_DEPTH),
    localparam int WADDR_W   = BANK_W + ROW_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ROW_W-1:0]   req_blk,
    output logic               req_ready,
    input  logic               wr_en,
    input  logic [WADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0]  wr_data,
    output logic               rd_valid,
    output logic               rd_last,
    output logic [WORD_W-1:0]  rd_data
);
    logic [ROW_W-1:0]  row;
    logic              sample;
    logic [BANK_W-1:0] sel;
    logic [WORD_W-1:0] bank_words [NUM_BANKS];

    im_ctrl #(
        .NUM_BANKS (NUM_BANKS),
        .ACCESS_LAT(ACCESS_LAT),
        .BLK_W     (ROW_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_blk   (req_blk),
        .req_ready (req_ready),
        .row       (row),
        .sample    (sample),
        .sel       (sel),
        .xfer_valid(rd_valid),
        .xfer_last (rd_last)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic bank_wr;
        // Route a write to the bank named by the low address bits.
        always_comb bank_wr = wr_en && (wr_addr[BANK_W-1:0] == BANK_W'(g));

        im_bank #(
            .WORD_W(WORD_W),
            .DEPTH (BANK_DEPTH)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (bank_wr),
            .wr_row   (wr_addr[WADDR_W-1:BANK_W]),
            .wr_data  (wr_data),
            .rd_sample(sample),
            .rd_row   (row),
            .rd_word  (bank_words[g])
        );
    end

    // Serialise the sampled bank words onto the return path.
    always_comb rd_data = bank_words[sel];
endmodule

// File: rtl/im_checker.sv
// Protocol and timing checks for interleaved_mem, bound to every instance.
// Assumes: counters are sized for ACCESS_LAT + NUM_BANKS < 65536.
module im_checker #(
    parameter int NUM_BANKS  = 4,
    parameter int ACCESS_LAT = 6
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic rd_valid,
    input logic rd_last
);
    logic [15:0] cyc_q;
    logic [15:0] vcnt_q;

    // Cycles since acceptance and words returned in the current block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q  <= '0;
            vcnt_q <= '0;
        end else begin
            if (req_valid && req_ready) cyc_q <= 16'd1;
            else if (rd_last)           cyc_q <= '0;
            else if (cyc_q != '0)       cyc_q <= cyc_q + 16'd1;
            if (rd_last)       vcnt_q <= '0;
            else if (rd_valid) vcnt_q <= vcnt_q + 16'd1;
        end
    end

    assert_accept_drops_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    assert_valid_while_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !req_ready);
    assert_first_word_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> (int'(cyc_q) == ACCESS_LAT + 2));
    assert_last_word_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |-> (int'(cyc_q) == 1 + ACCESS_LAT + NUM_BANKS));
    assert_burst_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |-> (rd_valid && int'(vcnt_q) == NUM_BANKS - 1));
    assert_ready_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |=> (req_ready && !rd_valid));
endmodule

bind interleaved_mem im_checker #(
    .NUM_BANKS (NUM_BANKS),
    .ACCESS_LAT(ACCESS_LAT)
) u_im_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .rd_valid (rd_valid),
    .rd_last  (rd_last)
);

// File: tb/interleaved_mem_bench.sv
// Self-checking bench with a behavioural reference model compared every cycle.
module interleaved_mem_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NB   = 4;
    localparam int LAT  = 6;
    localparam int DEP  = 16;
    localparam int WORDS = NB * DEP;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0;
    logic [3:0]  req_blk = '0;
    logic        req_ready;
    logic        wr_en = 0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_valid, rd_last;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    string phase = "R1";

    interleaved_mem u_interleaved_mem (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_blk(req_blk),
        .req_ready(req_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_last(rd_last), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model state
    logic [31:0] m_mem [WORDS];
    logic [31:0] m_snap [NB];
    bit          m_busy;
    int          m_t;
    int          m_blk;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_t = 0; m_blk = 0;
            for (int i = 0; i < WORDS; i++) m_mem[i] = '0;
            for (int i = 0; i < NB; i++) m_snap[i] = '0;
        end else begin
            bit acc;
            acc = !m_busy && req_valid;
            if (m_busy) begin
                m_t++;
                if (m_t == LAT + 1)
                    for (int i = 0; i < NB; i++) m_snap[i] = m_mem[m_blk * NB + i];
                if (m_t == LAT + NB + 1) m_busy = 0;
            end
            if (wr_en) m_mem[wr_addr] = wr_data;
            if (acc) begin m_busy = 1; m_t = 0; m_blk = req_blk; end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (phase %s) t=%0t actual=%h expected=%h", tag, phase, $time, act, exp);
        end
    endtask

    // Compare outputs against the model away from the active edge.
    always @(negedge clk) begin
        bit ev, el;
        ev = m_busy && m_t >= LAT + 1 && m_t <= LAT + NB;
        el = m_busy && m_t == LAT + NB;
        check("R2 ready", {31'd0, req_ready}, {31'd0, !m_busy});
        check("R3 valid", {31'd0, rd_valid}, {31'd0, ev});
        check("R5 last", {31'd0, rd_last}, {31'd0, el});
        if (ev) check("R4 data", rd_data, m_snap[m_t - (LAT + 1)]);
    end

    task automatic wait_idle();
        while (!req_ready) @(negedge clk);
    endtask

    task automatic read_blk(input int b);
        wait_idle();
        req_valid = 1; req_blk = 4'(b);
        @(negedge clk);
        req_valid = 0;
        @(negedge clk);
        wait_idle();
    endtask

    task automatic write_word(input int a, input logic [31:0] d);
        wr_en = 1; wr_addr = 6'(a); wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state and all-zero contents
        phase = "R1";
        check("R1 ready", {31'd0, req_ready}, 32'd1);
        check("R1 valid", {31'd0, rd_valid}, 32'd0);
        for (int b = 0; b < DEP; b++) read_blk(b);

        // R6 / R4: fill, then read blocks in mixed order
        phase = "R6";
        for (int a = 0; a < WORDS; a++) write_word(a, 32'hA500_0000 ^ (32'(a) * 32'h0001_0203));
        phase = "R4";
        read_blk(0); read_blk(5); read_blk(15); read_blk(9);

        // R7: writes around the bank sampling edge
        phase = "R7";
        wait_idle();
        req_valid = 1; req_blk = 4'd3;
        @(negedge clk); req_valid = 0;              // after accept edge
        repeat (2) @(negedge clk);
        write_word(13, 32'h1111_0001);              // edge 3: returned
        repeat (3) @(negedge clk);
        write_word(14, 32'h2222_0002);              // edge 7: not returned
        @(negedge clk);
        write_word(12, 32'h3333_0003);              // edge 9: not returned
        wait_idle();
        read_blk(3);                                // all three new words

        // R8, R9: request held high with changing block, writes mixed in
        phase = "R8,R9";
        req_valid = 1;
        for (int k = 0; k < 40; k++) begin
            req_blk = 4'(k * 7);
            wr_en = (k % 5 == 2); wr_addr = 6'(k + 20); wr_data = 32'hC0DE_0000 + 32'(k);
            @(negedge clk);
        end
        req_valid = 0; wr_en = 0;
        @(negedge clk);
        wait_idle();
        repeat (3) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog expired (phase %s)", phase);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule